// File: doc/BRIEF.md
# Clock Synthesizer Parameter Register File

This block keeps the divider settings of three clock synthesizers (pixel, memory and loop). Each synthesizer has three parameter bytes: an input divider N, a feedback divider M and a post-scaler exponent P. The host reaches all nine bytes through four ports that share one select field. Port 0 is a shared pointer byte. Ports 1, 2 and 3 are the data windows of the pixel, memory and loop synthesizers. The pointer byte packs one 2-bit slot pointer per synthesizer. A data write lands in the slot its pointer names, and that pointer then steps to the next slot. A burst of writes can therefore fill N, M and P in order without reloading the pointer.

The block also turns the pixel synthesizer's settings into a registered rational frequency, numerator over denominator in hertz. A two-bit source selector can replace the synthesizer output with one of two fixed reference frequencies. The analogue loops themselves sit outside the block, and so does the host logic that decides when these ports are addressed.

Top module: `pll_param_regfile`

## Requirements
- R1: While reset is high and in the first cycle after it, the pointer byte and all nine parameter bytes are 0, `host_rdata` is 0 and `host_rvalid` is 0. `freq_num`/`freq_den` read 25175000/1.
- R2: A write on port 0 stores the whole byte into the pointer byte. A read on port 0 returns the pointer byte.
- R3: The pointer of the pixel synthesizer is bits 1:0 of the pointer byte, the memory pointer is bits 3:2 and the loop pointer is bits 5:4. A write on port 1, 2 or 3 stores the byte in the slot its own pointer names: 0 is N, 1 is M, 2 is P.
- R4: After a write on data port k, only that port's 2-bit pointer changes, by +1 modulo 4. Every other bit of the pointer byte, bits 7:6 included, keeps its value.
- R5: A data write while the port's pointer is 3 leaves all parameter bytes unchanged, and the pointer wraps to 0.
- R6: A read on a data port returns the byte its pointer names. For pointer 3, the pixel and memory ports return 0x40 (locked) and the loop port returns 0xFF.
- R7: Reads never change the pointer byte.
- R8: A read accepted at a clock edge presents its data on `host_rdata` after that edge, with `host_rvalid` high for one cycle. `host_rdata` holds its value otherwise. When a read and a write arrive in the same cycle, the read returns the state from before the write.
- R9: When `clk_src` is 2 or 3, one cycle after any input change `freq_num` = 8·14318184·(65 − M[5:0]) and `freq_den` = (65 − N[5:0])·2^P[1:0], using the pixel synthesizer's bytes.
- R10: When `clk_src` is 0 the outputs become 25175000/1, and when it is 1 they become 28322000/1, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the selected port |
| host_rd | input | 1 | Read strobe for the selected port |
| host_port | input | 2 | 0 pointer byte, 1 pixel, 2 memory, 3 loop |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle per read |
| clk_src | input | 2 | 0/1 fixed references, 2/3 pixel synthesizer |
| freq_num | output | 34 | Output frequency numerator in Hz |
| freq_den | output | 10 | Output frequency denominator |

## Verification
Suppose a pointer steps on the wrong port or fails to wrap. Then the next read of the pointer byte shows it, and the next data read or write uses the wrong slot, so the error appears on `host_rdata` one cycle after the following read. A parameter byte stored in the wrong place shows up one cycle later on `freq_num`/`freq_den` if it belongs to the pixel synthesizer, and on the next read of that slot otherwise. A bench model predicts every output on every cycle, so a wrong value is caught in the cycle it first appears.

// File: rtl/pllrf_pkg.sv
package pllrf_pkg;
  localparam int NUM_SYN = 3;
  localparam int NUM_PRM = 3;
  localparam int PTR_W   = 2;
  localparam int FLD_W   = 6;
  localparam int EXP_W   = 2;

  typedef enum logic [1:0] {
    PORT_ADDR = 2'd0,
    PORT_PIX  = 2'd1,
    PORT_MEM  = 2'd2,
    PORT_LOOP = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    SLOT_N    = 2'd0,
    SLOT_M    = 2'd1,
    SLOT_P    = 2'd2,
    SLOT_LOCK = 2'd3
  } slot_e;
endpackage

// File: rtl/pllrf_ptr_reg.sv
module pllrf_ptr_reg
  import pllrf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [NUM_SYN-1:0] step,
  output logic [DATA_W-1:0] addr_q
);
  logic [DATA_W-1:0] addr_nxt;

  always_comb begin
    addr_nxt = addr_q;
    for (int s = 0; s < NUM_SYN; s++) begin
      if (step[s]) addr_nxt[s*PTR_W +: PTR_W] = addr_q[s*PTR_W +: PTR_W] + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= load_data;
    else           addr_q <= addr_nxt;
  end

  // only one data port is strobed per cycle
  p_one_step_r4: assert property (@(posedge clk) disable iff (rst) $onehot0(step));

  p_read_still_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && step == '0) |=> $stable(addr_q));

  for (genvar s = 0; s < NUM_SYN; s++) begin : g_chk
    localparam logic [DATA_W-1:0] FMASK = DATA_W'(((1 << PTR_W) - 1) << (s*PTR_W));
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
      (step[s] && !load) |=>
        ((addr_q[s*PTR_W +: PTR_W] == PTR_W'($past(addr_q[s*PTR_W +: PTR_W]) + 1)) &&
         (((addr_q ^ $past(addr_q)) & ~FMASK) == '0)));
  end
endmodule

// File: rtl/pllrf_bank.sv
module pllrf_bank
  import pllrf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [PTR_W-1:0]                 ptr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_PRM-1:0][DATA_W-1:0]   prm_q
);
  for (genvar k = 0; k < NUM_PRM; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                             prm_q[k] <= '0;
      else if (we && ptr == PTR_W'(k))     prm_q[k] <= wdata;
    end

    p_store_r3: assert property (@(posedge clk) disable iff (rst)
      (we && ptr == PTR_W'(k)) |=> (prm_q[k] == $past(wdata)));
  end

  p_slot3_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (we && ptr == SLOT_LOCK) |=> $stable(prm_q));
endmodule

// File: rtl/pllrf_freq.sv
module pllrf_freq
  import pllrf_pkg::*;
#(
  parameter int NUM_W   = 34,
  parameter int DEN_W   = 10,
  parameter int REF_HZ  = 14318184,
  parameter int BYP0_HZ = 25175000,
  parameter int BYP1_HZ = 28322000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       clk_src,
  input  logic [FLD_W-1:0] n_fld,
  input  logic [FLD_W-1:0] m_fld,
  input  logic [EXP_W-1:0] p_fld,
  output logic [NUM_W-1:0] num_q,
  output logic [DEN_W-1:0] den_q
);
  localparam int BASE = (1 << FLD_W) + 1;
  localparam int DEN_MAX = BASE << ((1 << EXP_W) - 1);
  localparam logic [NUM_W-1:0] REF_X8 = NUM_W'(REF_HZ) << 3;

  logic [FLD_W:0]     n_term, m_term;
  logic [NUM_W-1:0]   num_c;
  logic [DEN_W-1:0]   den_c;

  always_comb begin
    n_term = (FLD_W+1)'(BASE) - {1'b0, n_fld};
    m_term = (FLD_W+1)'(BASE) - {1'b0, m_fld};
    unique case (clk_src)
      2'd0: begin num_c = NUM_W'(BYP0_HZ); den_c = DEN_W'(1); end
      2'd1: begin num_c = NUM_W'(BYP1_HZ); den_c = DEN_W'(1); end
      default: begin
        num_c = REF_X8 * NUM_W'(m_term);
        den_c = DEN_W'(n_term) << p_fld;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q <= NUM_W'(BYP0_HZ);
      den_q <= DEN_W'(1);
    end else begin
      num_q <= num_c;
      den_q <= den_c;
    end
  end

  p_bypass_den_r10: assert property (@(posedge clk) disable iff (rst)
    (clk_src < 2'd2) |=> (den_q == DEN_W'(1)));

  p_den_range_r9: assert property (@(posedge clk) disable iff (rst)
    (clk_src >= 2'd2) |=> (den_q >= DEN_W'(2) && den_q <= DEN_W'(DEN_MAX)));
endmodule

// File: rtl/pll_param_regfile.sv
module pll_param_regfile
  import pllrf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_W     = 34,
  parameter int DEN_W     = 10,
  parameter int REF_HZ    = 14318184,
  parameter int BYP0_HZ   = 25175000,
  parameter int BYP1_HZ   = 28322000,
  parameter logic [7:0] LOCK_PIX  = 8'h40,
  parameter logic [7:0] LOCK_MEM  = 8'h40,
  parameter logic [7:0] LOCK_LOOP = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_port,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic [1:0]        clk_src,
  output logic [NUM_W-1:0]  freq_num,
  output logic [DEN_W-1:0]  freq_den
);
  localparam logic [NUM_SYN-1:0][DATA_W-1:0] LOCK_TBL =
    {DATA_W'(LOCK_LOOP), DATA_W'(LOCK_MEM), DATA_W'(LOCK_PIX)};

  logic [DATA_W-1:0]                           addr_q;
  logic [NUM_SYN-1:0]                          step;
  logic                                        load;
  logic [NUM_SYN-1:0][PTR_W-1:0]               ptr_f;
  logic [NUM_SYN-1:0][NUM_PRM-1:0][DATA_W-1:0] prm_all;
  logic [NUM_SYN-1:0][DATA_W-1:0]              syn_rd;
  logic [DATA_W-1:0]                           rd_mux;

  assign load = host_wr && (host_port == PORT_ADDR);

  pllrf_ptr_reg #(.DATA_W(DATA_W)) u_ptr (
    .clk(clk), .rst(rst), .load(load), .load_data(host_wdata),
    .step(step), .addr_q(addr_q)
  );

  for (genvar s = 0; s < NUM_SYN; s++) begin : g_syn
    assign step[s]  = host_wr && (host_port == 2'(s + 1));
    assign ptr_f[s] = addr_q[s*PTR_W +: PTR_W];

    pllrf_bank #(.DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst(rst), .we(step[s]), .ptr(ptr_f[s]),
      .wdata(host_wdata), .prm_q(prm_all[s])
    );

    always_comb begin
      unique case (ptr_f[s])
        SLOT_N:  syn_rd[s] = prm_all[s][0];
        SLOT_M:  syn_rd[s] = prm_all[s][1];
        SLOT_P:  syn_rd[s] = prm_all[s][2];
        default: syn_rd[s] = LOCK_TBL[s];
      endcase
    end
  end

  always_comb begin
    unique case (host_port)
      PORT_ADDR: rd_mux = addr_q;
      PORT_PIX:  rd_mux = syn_rd[0];
      PORT_MEM:  rd_mux = syn_rd[1];
      default:   rd_mux = syn_rd[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_mux;
    end
  end

  pllrf_freq #(
    .NUM_W(NUM_W), .DEN_W(DEN_W), .REF_HZ(REF_HZ),
    .BYP0_HZ(BYP0_HZ), .BYP1_HZ(BYP1_HZ)
  ) u_freq (
    .clk(clk), .rst(rst), .clk_src(clk_src),
    .n_fld(prm_all[0][0][FLD_W-1:0]),
    .m_fld(prm_all[0][1][FLD_W-1:0]),
    .p_fld(prm_all[0][2][EXP_W-1:0]),
    .num_q(freq_num), .den_q(freq_den)
  );

  p_rvalid_r8: assert property (@(posedge clk) disable iff (rst)
    host_rvalid == $past(host_rd));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));

  p_lock_r6: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_port == PORT_PIX && ptr_f[0] == SLOT_LOCK) |=> (host_rdata == DATA_W'(LOCK_PIX)));
endmodule

// File: tb/pll_param_regfile_tb_top.sv
module pll_param_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_port = 2'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic [1:0]  clk_src = 2'd0;
  logic [33:0] freq_num;
  logic [9:0]  freq_den;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pll_param_regfile dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_port(host_port), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .clk_src(clk_src),
    .freq_num(freq_num), .freq_den(freq_den)
  );

  // behavioural reference
  int     m_addr;
  int     pv [3][3];
  longint m_rd, m_rv, m_num, m_den;
  int     m_src;

  function automatic int model_read(int port);
    int sh, ptr;
    if (port == 0) return m_addr;
    sh = 2*(port-1);
    ptr = (m_addr >> sh) & 3;
    if (ptr == 3) return (port == 3) ? 8'hFF : 8'h40;
    return pv[port-1][ptr];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_rd = 0; m_rv = 0; m_num = 25175000; m_den = 1; m_src = 0;
      for (int a = 0; a < 3; a++) for (int b = 0; b < 3; b++) pv[a][b] = 0;
    end else begin
      m_src = int'(clk_src);
      if (clk_src == 2'd0)      begin m_num = 25175000; m_den = 1; end
      else if (clk_src == 2'd1) begin m_num = 28322000; m_den = 1; end
      else begin
        m_num = longint'(114545472) * (65 - (pv[0][1] & 63));
        m_den = (65 - (pv[0][0] & 63)) << (pv[0][2] & 3);
      end
      m_rv = host_rd;
      if (host_rd) m_rd = model_read(int'(host_port));
      if (host_wr) begin
        if (host_port == 2'd0) m_addr = int'(host_wdata);
        else begin
          int s, sh, ptr;
          s = int'(host_port) - 1; sh = 2*s;
          ptr = (m_addr >> sh) & 3;
          if (ptr < 3) pv[s][ptr] = int'(host_wdata);
          m_addr = (m_addr & ~(3 << sh)) | (((ptr + 1) & 3) << sh);
        end
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 rdata", longint'(host_rdata), m_rd);
      chk("R8 rvalid", longint'(host_rvalid), m_rv);
      if (m_src < 2) begin
        chk("R10 num", longint'(freq_num), m_num);
        chk("R10 den", longint'(freq_den), m_den);
      end else begin
        chk("R9 num", longint'(freq_num), m_num);
        chk("R9 den", longint'(freq_den), m_den);
      end
    end
  end

  task automatic op(input bit w, input bit r, input logic [1:0] port, input logic [7:0] d);
    host_wr = w; host_rd = r; host_port = port; host_wdata = d;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
  endtask

  task automatic wr(input logic [1:0] port, input logic [7:0] d); op(1, 0, port, d); endtask
  task automatic rd(input logic [1:0] port); op(0, 1, port, 8'h00); endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", longint'(host_rdata), 0);
    chk("R1 rvalid in reset", longint'(host_rvalid), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 num", longint'(freq_num), 25175000);
    chk("R1 den", longint'(freq_den), 1);
    rd(2'd0);
    chk("R1 ptr byte", longint'(host_rdata), 0);

    wr(2'd0, 8'hC0); rd(2'd0);
    chk("R2 ptr byte", longint'(host_rdata), 8'hC0);

    wr(2'd1, 8'h12); wr(2'd1, 8'h34); wr(2'd1, 8'h01); wr(2'd1, 8'h99);
    rd(2'd0);
    chk("R5 wrap", longint'(host_rdata), 8'hC0);
    rd(2'd1); chk("R3 pixel N", longint'(host_rdata), 8'h12);
    rd(2'd1); chk("R7 repeat read", longint'(host_rdata), 8'h12);
    rd(2'd0); chk("R7 ptr unchanged", longint'(host_rdata), 8'hC0);

    wr(2'd2, 8'h05); rd(2'd0);
    chk("R4 mem step only", longint'(host_rdata), 8'hC4);
    rd(2'd2); chk("R6 mem M", longint'(host_rdata), 0);
    wr(2'd0, 8'h0C); rd(2'd2); chk("R6 mem lock", longint'(host_rdata), 8'h40);
    wr(2'd0, 8'h03); rd(2'd1); chk("R6 pixel lock", longint'(host_rdata), 8'h40);
    wr(2'd0, 8'h30); rd(2'd3); chk("R6 loop lock", longint'(host_rdata), 8'hFF);
    wr(2'd3, 8'h77); rd(2'd0); chk("R5 loop wrap", longint'(host_rdata), 8'h00);

    wr(2'd0, 8'h10); wr(2'd3, 8'h2A); rd(2'd0);
    chk("R4 loop step", longint'(host_rdata), 8'h20);
    wr(2'd0, 8'h10); rd(2'd3); chk("R3 loop M", longint'(host_rdata), 8'h2A);

    clk_src = 2'd2;
    @(negedge clk); @(negedge clk);
    chk("R9 num", longint'(freq_num), 64'd1489091136);
    chk("R9 den", longint'(freq_den), 94);
    wr(2'd0, 8'h00); wr(2'd1, 8'hD2); @(negedge clk);
    chk("R9 masked N den", longint'(freq_den), 94);
    clk_src = 2'd1;
    @(negedge clk); @(negedge clk);
    chk("R10 num", longint'(freq_num), 28322000);
    chk("R10 den", longint'(freq_den), 1);

    wr(2'd0, 8'h00);
    op(1, 1, 2'd1, 8'h77);
    chk("R8 read before write", longint'(host_rdata), 8'hD2);
    rd(2'd1); chk("R8 next slot", longint'(host_rdata), 8'h34);

    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0) clk_src = 2'($urandom_range(0, 3));
      op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
         2'($urandom_range(0, 3)), 8'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule